// File: doc/BRIEF.md
# Cascade ID Buffer and Comparator

This block owns the three-line cascade bus that links several interrupt controllers into one tree. A controller set up as the master, on the first acknowledge pulse of a sequence, puts the identity of the winning level on the cascade lines and holds it there until the sequence ends. It drives that identity only when the level has a subordinate controller attached; for any other level it keeps the lines at zero and raises its own vector-enable flag instead. A controller set up as a subordinate listens to the same lines and compares them with its programmed identity. On a match it raises the vector-enable flag, which lets it place its vector bytes on the data bus for the rest of the sequence.

An acknowledge sequence has either two or three pulses, selected at its first pulse. If no request is valid when the first pulse arrives, the block handles the acknowledge as a level-7 acknowledge. Priority resolution and the vector bytes themselves belong to neighbouring blocks. The mode input is sampled only at the start of a sequence, and reset puts the block in subordinate mode.

Top module: `cas_id_unit`

## Requirements
- R1: In master mode, on a sequence start with a valid request whose level has its `slave_mask` bit set, `cas_oe` is high and `cas_out` equals that level from the cycle after the first pulse is sampled until the sequence ends, and `cas_out` stays constant throughout.
- R2: In master mode, if the started level's `slave_mask` bit is clear, `cas_out` is 0 and `vec_en` is high for the whole sequence.
- R3: If `req_valid` is low when the first pulse is sampled, the sequence uses level 7 (binary 111). `cas_out` is 7 when `slave_mask[7]` is set. Otherwise `cas_out` is 0 and `vec_en` is high.
- R4: `cas_oe` is high only inside a master sequence. It is low in subordinate mode and between sequences.
- R5: When `long_seq` is 1 at the first pulse, the sequence lasts three pulses; when it is 0, two. All outputs clear on the clock edge that samples `ack` low after the final pulse.
- R6: In subordinate mode, on the edge that samples the end of the first pulse, `vec_en` becomes `cas_in == own_id`. It holds that value until the sequence ends. Later changes on `cas_in` have no effect.
- R7: In master mode `cas_in` and `own_id` have no effect on any output.
- R8: A synchronous low `rst_n` clears all outputs and selects subordinate mode.
- R9: Changes on `win_level`, `slave_mask`, `req_valid`, `is_master` and `long_seq` during a sequence have no effect until the next sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| is_master | input | 1 | 1 selects master mode, sampled at sequence start |
| own_id | input | 3 | Programmed subordinate identity |
| req_valid | input | 1 | A request is pending at the first pulse |
| win_level | input | 3 | Winning priority level |
| slave_mask | input | 8 | Per-level "subordinate attached" flags |
| long_seq | input | 1 | 1 selects a three-pulse sequence, 0 a two-pulse one |
| ack | input | 1 | Acknowledge pulse stream, active high |
| cas_in | input | 3 | Sampled cascade lines |
| cas_out | output | 3 | Cascade value driven by a master |
| cas_oe | output | 1 | Cascade output enable |
| vec_en | output | 1 | This controller supplies the vector |

## Verification
The bench tests both sequence lengths. A design that miscounted pulses would drop `cas_oe` one pulse early or hold it one pulse too long. It also tests the spurious acknowledge both with and without a subordinate on level 7: a wrong design would show a stale level or drive the lines when it should supply the vector itself. In subordinate mode, `cas_in` changes after the first pulse; a comparator that did not latch would flip `vec_en` mid-sequence. The mode and level inputs change while a sequence is running, and in master mode `cas_in` is set to match `own_id`; both expose any path that leaks live inputs into the outputs.

// File: rtl/cas_pkg.sv
// Package: shared widths and constants for the cascade identity unit.
// Assumes a power-of-two level count derived from the identity width.
package cas_pkg;
    localparam int ID_W       = 3;
    localparam int LEVELS     = 1 << ID_W;
    localparam int MAX_PULSES = 3;
    localparam int MIN_PULSES = 2;
    localparam int CNT_W      = $clog2(MAX_PULSES + 1);

    typedef logic [ID_W-1:0] cas_id_t;

    // Level used when an acknowledge finds no pending request
    localparam cas_id_t SPURIOUS_LVL = cas_id_t'(LEVELS - 1);
endpackage

// File: rtl/cas_ack_tracker.sv
// Module: follows the acknowledge pulse stream and frames one sequence.
// Produces single-cycle start, first-pulse-end and done strobes.
// Assumes ack is already synchronous to clk.
module cas_ack_tracker
    import cas_pkg::*;
#(
    parameter int LONG_LEN  = MAX_PULSES,
    parameter int SHORT_LEN = MIN_PULSES,
    localparam int CW       = $clog2(LONG_LEN + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ack,
    input  logic long_seq,
    output logic seq_start,
    output logic first_end,
    output logic seq_done,
    output logic active
);
    logic          ack_q;
    logic          active_q;
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] last_q;
    logic          rise;
    logic          fall;

    // Edge detection and sequence strobes
    always_comb begin
        rise      = ack & ~ack_q;
        fall      = ~ack & ack_q;
        seq_start = rise & ~active_q;
        first_end = fall & active_q & (cnt_q == CW'(1));
        seq_done  = fall & active_q & (cnt_q == last_q);
    end

    // Pulse counter and sequence-active state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q    <= 1'b0;
            active_q <= 1'b0;
            cnt_q    <= '0;
            last_q   <= '0;
        end else begin
            ack_q <= ack;
            if (seq_start) begin
                active_q <= 1'b1;
                cnt_q    <= CW'(1);
                last_q   <= long_seq ? CW'(LONG_LEN) : CW'(SHORT_LEN);
            end else if (seq_done) begin
                active_q <= 1'b0;
                cnt_q    <= '0;
            end else if (active_q && rise && cnt_q != last_q) begin
                cnt_q <= cnt_q + CW'(1);
            end
        end
    end

    assign active = active_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active_q |-> (cnt_q != '0 && cnt_q <= last_q)); // R5

    AST_DONE_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> !active_q); // R5
endmodule

// File: rtl/cas_master_drv.sv
// Module: master-side cascade driver. At sequence start it picks the
// level (level 7 if no request is pending) and drives it on the cascade
// lines when a subordinate is attached; otherwise it claims the vector.
// Assumes seq_start and seq_done are single-cycle strobes.
module cas_master_drv
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_start,
    input  logic              seq_done,
    input  logic              is_master,
    input  logic              req_valid,
    input  cas_id_t           win_level,
    input  logic [LEVELS-1:0] slave_mask,
    output cas_id_t           cas_out,
    output logic              cas_oe,
    output logic              own_vec
);
    cas_id_t lvl;
    logic    attached;

    // Level selection, with spurious acknowledges mapped to level 7
    always_comb begin
        lvl      = req_valid ? win_level : SPURIOUS_LVL;
        attached = slave_mask[lvl];
    end

    // Drive registers, loaded at start and cleared at done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cas_out <= '0;
            cas_oe  <= 1'b0;
            own_vec <= 1'b0;
        end else if (seq_start) begin
            cas_oe  <= is_master;
            cas_out <= (is_master && attached) ? lvl : '0;
            own_vec <= is_master && !attached;
        end else if (seq_done) begin
            cas_out <= '0;
            cas_oe  <= 1'b0;
            own_vec <= 1'b0;
        end
    end

    AST_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cas_oe && !seq_done && !seq_start) |=> $stable(cas_out)); // R1

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_oe |-> (cas_out == '0 && !own_vec)); // R4
endmodule

// File: rtl/cas_slave_cmp.sv
// Module: subordinate-side identity comparator. Latches the match of the
// cascade lines against its own identity when the first pulse ends and
// holds it until the sequence ends.
// Assumes the master has settled the cascade lines by then.
module cas_slave_cmp
    import cas_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    first_end,
    input  logic    seq_done,
    input  logic    slave_mode,
    input  cas_id_t cas_in,
    input  cas_id_t own_id,
    output logic    match_vec
);
    // Latch the identity match once per sequence
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            match_vec <= 1'b0;
        end else if (seq_done) begin
            match_vec <= 1'b0;
        end else if (first_end) begin
            match_vec <= slave_mode && (cas_in == own_id);
        end
    end

    AST_MATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (match_vec && !seq_done) |=> match_vec); // R6
endmodule

// File: rtl/cas_id_unit.sv
// Module: top of the cascade identity buffer and comparator. Holds the
// mode sampled at sequence start and joins the tracker, master driver
// and subordinate comparator. Reset selects subordinate mode.
module cas_id_unit
    import cas_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              is_master,
    input  logic [ID_W-1:0]   own_id,
    input  logic              req_valid,
    input  logic [ID_W-1:0]   win_level,
    input  logic [LEVELS-1:0] slave_mask,
    input  logic              long_seq,
    input  logic              ack,
    input  logic [ID_W-1:0]   cas_in,
    output logic [ID_W-1:0]   cas_out,
    output logic              cas_oe,
    output logic              vec_en
);
    logic seq_start;
    logic first_end;
    logic seq_done;
    logic active;
    logic mode_q;
    logic own_vec;
    logic match_vec;

    cas_ack_tracker u_trk (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack       (ack),
        .long_seq  (long_seq),
        .seq_start (seq_start),
        .first_end (first_end),
        .seq_done  (seq_done),
        .active    (active)
    );

    // Mode register, sampled only when a sequence starts
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= 1'b0;
        else if (seq_start) mode_q <= is_master;
    end

    cas_master_drv u_mst (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_start  (seq_start),
        .seq_done   (seq_done),
        .is_master  (is_master),
        .req_valid  (req_valid),
        .win_level  (win_level),
        .slave_mask (slave_mask),
        .cas_out    (cas_out),
        .cas_oe     (cas_oe),
        .own_vec    (own_vec)
    );

    cas_slave_cmp u_slv (
        .clk        (clk),
        .rst_n      (rst_n),
        .first_end  (first_end),
        .seq_done   (seq_done),
        .slave_mode (!mode_q),
        .cas_in     (cas_in),
        .own_id     (own_id),
        .match_vec  (match_vec)
    );

    // Either side may claim the vector
    assign vec_en = own_vec | match_vec;

    AST_OE_IN_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        cas_oe |-> (active && mode_q)); // R4

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |=> (!cas_oe && !vec_en)); // R5

    AST_ONE_VEC_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        !(own_vec && match_vec)); // R7

    AST_NO_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> !vec_en); // R6
endmodule

// File: tb/tb_cas_id_unit.sv
module tb_cas_id_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       is_master = 1'b0;
    logic [2:0] own_id = 3'd0;
    logic       req_valid = 1'b0;
    logic [2:0] win_level = 3'd0;
    logic [7:0] slave_mask = 8'h00;
    logic       long_seq = 1'b0;
    logic       ack = 1'b0;
    logic [2:0] cas_in = 3'd0;
    logic [2:0] cas_out;
    logic       cas_oe;
    logic       vec_en;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    string scen = "R8";
    bit done = 0;

    // Reference model state
    int m_prev = 0, m_in = 0, m_pulses = 0, m_need = 0, m_lvl = 0, m_mst = 0;
    int e_out = 0, e_oe = 0, e_vec = 0;

    cas_id_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference, advanced once per rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_prev = 0; m_in = 0; m_pulses = 0; m_mst = 0;
            e_out = 0; e_oe = 0; e_vec = 0;
        end else begin
            if (m_in == 0 && ack && m_prev == 0) begin
                m_in = 1; m_pulses = 1;
                m_need = long_seq ? 3 : 2;
                m_lvl = req_valid ? int'(win_level) : 7;
                m_mst = is_master;
                if (m_mst != 0) begin
                    e_oe = 1;
                    e_out = slave_mask[m_lvl] ? m_lvl : 0;
                    e_vec = slave_mask[m_lvl] ? 0 : 1;
                end else begin
                    e_oe = 0; e_out = 0; e_vec = 0;
                end
            end else if (m_in != 0 && ack && m_prev == 0) begin
                m_pulses++;
            end else if (m_in != 0 && !ack && m_prev != 0) begin
                if (m_pulses == m_need) begin
                    m_in = 0; e_oe = 0; e_out = 0; e_vec = 0;
                end else if (m_pulses == 1 && m_mst == 0) begin
                    e_vec = (cas_in == own_id) ? 1 : 0;
                end
            end
            m_prev = ack ? 1 : 0;
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (int'(cas_out) != e_out) begin
                fails++;
                $display("FAIL %s/R1 cas_out act %0d exp %0d t=%0t", scen, cas_out, e_out, $time);
            end
            checks++;
            if (int'(cas_oe) != e_oe) begin
                fails++;
                $display("FAIL %s/R4 cas_oe act %0d exp %0d t=%0t", scen, cas_oe, e_oe, $time);
            end
            checks++;
            if (int'(vec_en) != e_vec) begin
                fails++;
                $display("FAIL %s/R6 vec_en act %0d exp %0d t=%0t", scen, vec_en, e_vec, $time);
            end
        end
    end

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk); ack = 1'b1;
        wait_n(hi);
        ack = 1'b0;
        wait_n(lo);
    endtask

    task automatic run_seq(input int n);
        for (int i = 0; i < n; i++) pulse(2, 2);
        wait_n(2);
    endtask

    task automatic finish_up();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        wait (cycles > 20000);
        fails++;
        $display("FAIL watchdog act %0d cycles exp under 20000", cycles);
        finish_up();
    end

    initial begin
        // R8: reset state, outputs idle in subordinate mode
        scen = "R8";
        wait_n(4);
        @(negedge clk); rst_n = 1'b1;
        wait_n(2);

        // R1: master, attached level 5, two pulses
        scen = "R1";
        is_master = 1; req_valid = 1; win_level = 3'd5; slave_mask = 8'b0010_0000; long_seq = 0;
        run_seq(2);

        // R2 and R5: unattached level 2, three pulses
        scen = "R2";
        win_level = 3'd2; long_seq = 1;
        run_seq(3);

        // R3: spurious acknowledge, level 7 attached
        scen = "R3";
        req_valid = 0; slave_mask = 8'h80; long_seq = 0;
        run_seq(2);
        // R3: spurious acknowledge, level 7 not attached
        slave_mask = 8'h7F;
        run_seq(2);

        // R9: inputs change mid-sequence
        scen = "R9";
        req_valid = 1; win_level = 3'd3; slave_mask = 8'h08; long_seq = 1;
        pulse(2, 2);
        win_level = 3'd6; slave_mask = 8'h00; is_master = 0; long_seq = 0; req_valid = 0;
        pulse(2, 2);
        pulse(2, 2);
        wait_n(2);

        // R7: master ignores matching cas_in/own_id
        scen = "R7";
        is_master = 1; req_valid = 1; win_level = 3'd1; slave_mask = 8'h02;
        own_id = 3'd4; cas_in = 3'd4;
        run_seq(2);

        // R6: subordinate match, two pulses
        scen = "R6";
        is_master = 0; own_id = 3'd3; cas_in = 3'd3; long_seq = 0;
        run_seq(2);
        // R6: subordinate mismatch, three pulses
        cas_in = 3'd2; long_seq = 1;
        run_seq(3);
        // R6: match latched, then cas_in moves away
        cas_in = 3'd3;
        pulse(2, 2);
        cas_in = 3'd0;
        pulse(2, 2);
        pulse(2, 2);
        wait_n(2);
        // R6: mismatch latched, then cas_in moves to match
        cas_in = 3'd6; long_seq = 0;
        pulse(1, 1);
        cas_in = 3'd3;
        pulse(1, 1);
        wait_n(2);

        // R5: back-to-back master sequences with one-cycle pulses
        scen = "R5";
        is_master = 1; slave_mask = 8'hFF; win_level = 3'd7;
        pulse(1, 1); pulse(1, 1);
        win_level = 3'd4; long_seq = 1;
        pulse(1, 1); pulse(1, 1); pulse(1, 3);

        // R8: reset in the middle of a sequence
        scen = "R8";
        pulse(2, 1);
        rst_n = 1'b0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(3);

        finish_up();
    end
endmodule